// File: doc/BRIEF.md
# Memory Ordering Dependence Tracker

This block works next to an out-of-order issue queue and decides when each memory operation may be offered for issue. Every dispatched load, store, full barrier or write-only barrier is written into a small table together with its sequence number, PC, thread and whether its register operands are already available. When a load or store arrives, the tracker looks for a producer. A pending full barrier is the producer of loads and stores. A pending write barrier is the producer of stores. Without a pending barrier, an external PC-indexed dependence predictor is asked for a likely producing store. A producer that is still held in the table makes the new operation wait.

Operations leave the waiting state when their producer completes, and become issuable once their registers are also ready. The issue queue takes the offered operation with an acknowledge. It can later send an issued operation back to a replay pool, and a single replay command releases the whole pool in one cycle. A squash removes all younger operations of one thread. A context reset between workloads clears the barrier state and pulses a clear to the predictor. The table holds a parameterised number of entries, and insertion is refused when it is full.

Top module: `mem_order_tracker`

## Requirements
- R1: Inserting a full barrier (kind code 2) makes every later load (kind 0) and store (kind 1) wait on it: `ins_blocked` is 1 in the insert cycle. Both stay held until the barrier completes.
- R2: Inserting a write-only barrier (kind 3) makes later stores wait on it. Later loads are not held by it and consult the predictor instead.
- R3: With no applicable barrier, `pred_pc` equals `ins_pc` and the producer is `pred_seq`. A value of zero means no producer. A nonzero value matching no valid table entry also means no producer. A match makes the new operation wait (`ins_blocked` = 1).
- R4: An operation is offered on `iss_valid/iss_seq/iss_tid` only when it is valid, is a load or store, has its registers ready, is not waiting on a producer, and has not already been issued or parked. Slots are filled lowest free index first, and the lowest-index eligible slot is offered. `iss_ack` marks the offered entry as issued. Right after reset nothing is offered.
- R5: Completing a sequence number (`done_valid`) frees that entry and releases every operation waiting on it. If the entry is the recorded barrier, the matching barrier flag clears and later operations no longer wait on it.
- R6: `park_valid` with the sequence number of an issued entry moves it to the replay pool, where it is not offered. `replay_req` returns every parked entry to the offerable state in the same cycle.
- R7: A squash removes every entry of `squash_tid` whose sequence number is greater than `squash_seq`. A recorded barrier removed this way also drops its flag. In a squash cycle, any insert and any replay request are ignored.
- R8: `ins_full` is 1 exactly when all table entries are occupied, barriers included. An insert presented while full is ignored.
- R9: `ctx_reset` clears both barrier flags and their recorded numbers, and drives `pred_clear` in the same cycle. It is only issued while the table is empty.
- R10: Barrier entries occupy the table but are never offered for issue.
- R11: An operation whose producer completes in the same cycle as its insert does not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_pc | input | PC_W | PC of the inserted operation |
| ins_tid | input | TID_W | Thread of the inserted operation |
| ins_regs_ready | input | 1 | Register operands already available |
| ins_full | output | 1 | No free entry; insert refused |
| ins_blocked | output | 1 | Accepted insert has a tracked producer |
| pred_pc | output | PC_W | PC presented to the dependence predictor |
| pred_seq | input | SEQ_W | Predicted producer sequence number, zero for none |
| pred_clear | output | 1 | Clears the predictor |
| wake_valid | input | 1 | Register operands became ready |
| wake_seq | input | SEQ_W | Sequence number being woken |
| done_valid | input | 1 | An operation completed |
| done_seq | input | SEQ_W | Sequence number that completed |
| park_valid | input | 1 | Send an issued operation to the replay pool |
| park_seq | input | SEQ_W | Sequence number to park |
| replay_req | input | 1 | Release every parked operation |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Entries with greater numbers are removed |
| ctx_reset | input | 1 | Clear barrier state and predictor |
| iss_valid | output | 1 | An operation is offered for issue |
| iss_seq | output | SEQ_W | Sequence number offered |
| iss_tid | output | TID_W | Thread of the offered operation |
| iss_ack | input | 1 | Offered operation taken by the issue queue |

## Verification
On every cycle the assertions check several properties. Barrier set commands must leave the matching flag and number recorded. A context reset must leave no flag behind, and it may only arrive with an empty table. A completed entry is gone one cycle later, a squash never grows the occupancy, and a full table stays full unless something leaves. A replay must empty the pool, and an acknowledged offer must not be repeated. Other behaviours appear only across the bench's scenarios: which producer a barrier or the predictor selects, waiting operations becoming offerable after a completion, the lowest-slot issue order, and squash beating a concurrent insert or replay. A free-running model checks these each cycle under random mixes of all commands.

// File: rtl/mot_pkg.sv
package mot_pkg;

    typedef enum logic [1:0] {
        MK_LOAD   = 2'd0,
        MK_STORE  = 2'd1,
        MK_FULLB  = 2'd2,
        MK_WRB    = 2'd3
    } mem_kind_e;

    function automatic logic kind_is_barrier(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/mot_seq_cam.sv
module mot_seq_cam #(
    parameter int N     = 16,
    parameter int SEQ_W = 16
) (
    input  logic [N-1:0]            en_i,
    input  logic [N-1:0][SEQ_W-1:0] seqs_i,
    input  logic                    key_valid_i,
    input  logic [SEQ_W-1:0]        key_i,
    output logic [N-1:0]            hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = key_valid_i && en_i[g] && (seqs_i[g] == key_i);
    end
endmodule

// File: rtl/mot_low_pick.sv
module mot_low_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mot_barrier_regs.sv
module mot_barrier_regs #(
    parameter int SEQ_W = 16,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             set_full_i,
    input  logic             set_wr_i,
    input  logic [SEQ_W-1:0] set_seq_i,
    input  logic [TID_W-1:0] set_tid_i,
    input  logic             done_valid_i,
    input  logic [SEQ_W-1:0] done_seq_i,
    input  logic             sq_valid_i,
    input  logic [TID_W-1:0] sq_tid_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    output logic             ld_on_o,
    output logic [SEQ_W-1:0] ld_seq_o,
    output logic             st_on_o,
    output logic [SEQ_W-1:0] st_seq_o
);
    typedef struct packed {
        logic             on;
        logic [SEQ_W-1:0] seq;
        logic [TID_W-1:0] tid;
    } bar_t;

    typedef struct packed {
        bar_t ld;
        bar_t st;
    } bstate_t;

    bstate_t bs_q, bs_d;

    function automatic logic gone(input bar_t b, input logic dv, input logic [SEQ_W-1:0] ds,
                                  input logic sv, input logic [TID_W-1:0] st,
                                  input logic [SEQ_W-1:0] ss);
        return b.on && ((dv && ds == b.seq) || (sv && st == b.tid && b.seq > ss));
    endfunction

    always_comb begin
        bs_d = bs_q;
        if (flush_i) begin
            bs_d = '0;
        end else begin
            if (gone(bs_q.ld, done_valid_i, done_seq_i, sq_valid_i, sq_tid_i, sq_seq_i))
                bs_d.ld.on = 1'b0;
            if (gone(bs_q.st, done_valid_i, done_seq_i, sq_valid_i, sq_tid_i, sq_seq_i))
                bs_d.st.on = 1'b0;
            if (set_full_i) begin
                bs_d.ld = '{on: 1'b1, seq: set_seq_i, tid: set_tid_i};
                bs_d.st = '{on: 1'b1, seq: set_seq_i, tid: set_tid_i};
            end else if (set_wr_i) begin
                bs_d.st = '{on: 1'b1, seq: set_seq_i, tid: set_tid_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign ld_on_o  = bs_q.ld.on;
    assign ld_seq_o = bs_q.ld.seq;
    assign st_on_o  = bs_q.st.on;
    assign st_seq_o = bs_q.st.seq;

    // R1: a full barrier records itself for both loads and stores
    a_r1_full_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        set_full_i && !flush_i |=> ld_on_o && st_on_o &&
            ld_seq_o == $past(set_seq_i) && st_seq_o == $past(set_seq_i));

    // R2: a write barrier records itself for stores
    a_r2_wr_sets_store: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr_i && !set_full_i && !flush_i |=> st_on_o && st_seq_o == $past(set_seq_i));

    // R9: context reset leaves no barrier recorded
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !ld_on_o && !st_on_o && ld_seq_o == '0 && st_seq_o == '0);
endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker #(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16,
    parameter int PC_W    = 32,
    parameter int THREADS = 2,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [1:0]       ins_kind,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [TID_W-1:0] ins_tid,
    input  logic             ins_regs_ready,
    output logic             ins_full,
    output logic             ins_blocked,
    output logic [PC_W-1:0]  pred_pc,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             pred_clear,
    input  logic             wake_valid,
    input  logic [SEQ_W-1:0] wake_seq,
    input  logic             done_valid,
    input  logic [SEQ_W-1:0] done_seq,
    input  logic             park_valid,
    input  logic [SEQ_W-1:0] park_seq,
    input  logic             replay_req,
    input  logic             squash_valid,
    input  logic [TID_W-1:0] squash_tid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             ctx_reset,
    output logic             iss_valid,
    output logic [SEQ_W-1:0] iss_seq,
    output logic [TID_W-1:0] iss_tid,
    input  logic             iss_ack
);
    import mot_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [1:0]       kind;
        logic [SEQ_W-1:0] seq;
        logic [TID_W-1:0] tid;
        logic             regs_rdy;
        logic             mem_wait;
        logic [IDX_W-1:0] prod;
        logic             issued;
        logic             parked;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRIES-1:0]            vld_v, park_v, rdy_v, kill_v, freed_v;
    logic [ENTRIES-1:0][SEQ_W-1:0] seq_v;
    logic [ENTRIES-1:0]            wake_hit, done_hit, park_hit, prod_hit;
    logic                          free_any, prod_any;
    logic [IDX_W-1:0]              free_idx, prod_idx, iss_idx;
    logic                          ins_take;
    logic [SEQ_W-1:0]              prod_seq;
    logic                          ld_on, st_on;
    logic [SEQ_W-1:0]              ld_seq, st_seq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign vld_v[g]  = st_q.ent[g].vld;
        assign seq_v[g]  = st_q.ent[g].seq;
        assign park_v[g] = st_q.ent[g].parked;
        assign rdy_v[g]  = st_q.ent[g].vld && !kind_is_barrier(st_q.ent[g].kind) &&
                           st_q.ent[g].regs_rdy && !st_q.ent[g].mem_wait &&
                           !st_q.ent[g].issued && !st_q.ent[g].parked;
        assign kill_v[g] = squash_valid && st_q.ent[g].vld &&
                           st_q.ent[g].tid == squash_tid && st_q.ent[g].seq > squash_seq;
        assign freed_v[g] = done_hit[g] || kill_v[g];
    end

    mot_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cam_wake (
        .en_i(vld_v), .seqs_i(seq_v), .key_valid_i(wake_valid), .key_i(wake_seq), .hit_o(wake_hit));
    mot_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cam_done (
        .en_i(vld_v), .seqs_i(seq_v), .key_valid_i(done_valid), .key_i(done_seq), .hit_o(done_hit));
    mot_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cam_park (
        .en_i(vld_v), .seqs_i(seq_v), .key_valid_i(park_valid), .key_i(park_seq), .hit_o(park_hit));
    mot_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cam_prod (
        .en_i(vld_v & ~done_hit), .seqs_i(seq_v), .key_valid_i(prod_seq != '0),
        .key_i(prod_seq), .hit_o(prod_hit));

    mot_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req_i(~vld_v), .any_o(free_any), .idx_o(free_idx));
    mot_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_prod (
        .req_i(prod_hit), .any_o(prod_any), .idx_o(prod_idx));
    mot_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_iss (
        .req_i(rdy_v), .any_o(iss_valid), .idx_o(iss_idx));

    mot_barrier_regs #(.SEQ_W(SEQ_W), .TID_W(TID_W)) u_bar (
        .clk(clk), .rst_n(rst_n), .flush_i(ctx_reset),
        .set_full_i(ins_take && ins_kind == MK_FULLB),
        .set_wr_i(ins_take && ins_kind == MK_WRB),
        .set_seq_i(ins_seq), .set_tid_i(ins_tid),
        .done_valid_i(done_valid), .done_seq_i(done_seq),
        .sq_valid_i(squash_valid), .sq_tid_i(squash_tid), .sq_seq_i(squash_seq),
        .ld_on_o(ld_on), .ld_seq_o(ld_seq), .st_on_o(st_on), .st_seq_o(st_seq));

    assign ins_full   = !free_any;
    assign ins_take   = ins_valid && free_any && !squash_valid;
    assign pred_pc    = ins_pc;
    assign pred_clear = ctx_reset;

    // Producer selection: barrier first, predictor otherwise; barriers have none
    always_comb begin
        prod_seq = '0;
        if (!kind_is_barrier(ins_kind)) begin
            if (ins_kind == MK_LOAD && ld_on)       prod_seq = ld_seq;
            else if (ins_kind == MK_STORE && st_on) prod_seq = st_seq;
            else                                    prod_seq = pred_seq;
        end
    end

    assign ins_blocked = ins_take && prod_any;
    assign iss_seq     = st_q.ent[iss_idx].seq;
    assign iss_tid     = st_q.ent[iss_idx].tid;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wake_hit[i]) st_d.ent[i].regs_rdy = 1'b1;
            if (park_hit[i] && st_q.ent[i].issued) begin
                st_d.ent[i].issued = 1'b0;
                st_d.ent[i].parked = 1'b1;
            end
        end
        if (iss_ack && iss_valid) st_d.ent[iss_idx].issued = 1'b1;
        if (replay_req && !squash_valid) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].parked = 1'b0;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].mem_wait && freed_v[st_q.ent[i].prod])
                st_d.ent[i].mem_wait = 1'b0;
            if (freed_v[i]) st_d.ent[i] = '0;
        end
        if (ins_take) begin
            st_d.ent[free_idx].vld      = 1'b1;
            st_d.ent[free_idx].kind     = ins_kind;
            st_d.ent[free_idx].seq      = ins_seq;
            st_d.ent[free_idx].tid      = ins_tid;
            st_d.ent[free_idx].regs_rdy = ins_regs_ready;
            st_d.ent[free_idx].mem_wait = prod_any;
            st_d.ent[free_idx].prod     = prod_idx;
            st_d.ent[free_idx].issued   = 1'b0;
            st_d.ent[free_idx].parked   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a completed entry is gone in the next cycle
    a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (($past(done_hit) & vld_v) == '0));

    // R7: a squash cycle never adds occupancy
    a_r7_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> $countones(vld_v) <= $past($countones(vld_v)));

    // R8: a full table stays full while nothing leaves
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full && !done_valid && !squash_valid |=> ins_full);

    // R6: replay empties the pool
    a_r6_replay_empties: assert property (@(posedge clk) disable iff (!rst_n)
        replay_req && !squash_valid && !park_valid |=> park_v == '0);

    // R9: context reset only with an empty table
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_reset |-> vld_v == '0);

    // R4: an acknowledged offer is not repeated in the next cycle
    a_r4_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ack |=> !(iss_valid && iss_seq == $past(iss_seq) &&
                                   iss_tid == $past(iss_tid)));
endmodule

// File: tb/mem_order_tracker_test.sv
`timescale 1ns/100ps
module mem_order_tracker_test;
    localparam int N = 16;
    localparam logic [1:0] KL = 2'd0, KS = 2'd1, KF = 2'd2, KW = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid, ins_regs_ready, ins_full, ins_blocked, pred_clear;
    logic [1:0] ins_kind;
    logic [15:0] ins_seq, pred_seq, wake_seq, done_seq, park_seq, squash_seq, iss_seq;
    logic [31:0] ins_pc, pred_pc;
    logic [0:0] ins_tid, squash_tid, iss_tid;
    logic wake_valid, done_valid, park_valid, replay_req, squash_valid, ctx_reset;
    logic iss_valid, iss_ack;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    mem_order_tracker uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
        .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_tid(ins_tid), .ins_regs_ready(ins_regs_ready),
        .ins_full(ins_full), .ins_blocked(ins_blocked), .pred_pc(pred_pc), .pred_seq(pred_seq),
        .pred_clear(pred_clear), .wake_valid(wake_valid), .wake_seq(wake_seq),
        .done_valid(done_valid), .done_seq(done_seq), .park_valid(park_valid),
        .park_seq(park_seq), .replay_req(replay_req), .squash_valid(squash_valid),
        .squash_tid(squash_tid), .squash_seq(squash_seq), .ctx_reset(ctx_reset),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_tid(iss_tid), .iss_ack(iss_ack));

    // Reference model state
    bit mv[N], mt[N], mrr[N], mw[N], mi[N], mpk[N];
    logic [15:0] ms[N];
    logic [1:0] mk[N];
    int mp[N];
    bit lb, sb, lbt, sbt;
    logic [15:0] lbs, sbs;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_full();
        for (int i = 0; i < N; i++) if (!mv[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_iss();
        for (int i = 0; i < N; i++)
            if (mv[i] && !mk[i][1] && mrr[i] && !mw[i] && !mi[i] && !mpk[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] m_prod_seq();
        if (ins_kind[1]) return 16'd0;
        if (ins_kind == KL && lb) return lbs;
        if (ins_kind == KS && sb) return sbs;
        return pred_seq;
    endfunction

    function automatic int m_find(input logic [15:0] s);
        if (s == 16'd0) return -1;
        for (int i = 0; i < N; i++)
            if (mv[i] && ms[i] == s && !(done_valid && done_seq == s)) return i;
        return -1;
    endfunction

    function automatic bit m_take();
        return ins_valid && !m_full() && !squash_valid;
    endfunction

    task automatic mdl_step();
        bit fr[N];
        int slot, pidx, ii;
        bit take;
        take = m_take();
        pidx = m_find(m_prod_seq());
        ii = m_iss();
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
        for (int i = 0; i < N; i++) begin
            if (mv[i] && wake_valid && ms[i] == wake_seq) mrr[i] = 1'b1;
            if (mv[i] && park_valid && ms[i] == park_seq && mi[i]) begin
                mi[i] = 1'b0; mpk[i] = 1'b1;
            end
        end
        if (iss_ack && ii >= 0) mi[ii] = 1'b1;
        if (replay_req && !squash_valid) for (int i = 0; i < N; i++) mpk[i] = 1'b0;
        for (int i = 0; i < N; i++)
            fr[i] = mv[i] && ((done_valid && ms[i] == done_seq) ||
                              (squash_valid && mt[i] == squash_tid && ms[i] > squash_seq));
        for (int i = 0; i < N; i++) if (mv[i] && mw[i] && fr[mp[i]]) mw[i] = 1'b0;
        for (int i = 0; i < N; i++) if (fr[i]) begin
            mv[i] = 0; mw[i] = 0; mi[i] = 0; mpk[i] = 0; mrr[i] = 0;
        end
        if (ctx_reset) begin
            lb = 0; sb = 0; lbs = 0; sbs = 0;
        end else begin
            if (lb && ((done_valid && done_seq == lbs) ||
                       (squash_valid && lbt == squash_tid && lbs > squash_seq))) lb = 0;
            if (sb && ((done_valid && done_seq == sbs) ||
                       (squash_valid && sbt == squash_tid && sbs > squash_seq))) sb = 0;
            if (take && ins_kind == KF) begin
                lb = 1; lbs = ins_seq; lbt = ins_tid[0]; sb = 1; sbs = ins_seq; sbt = ins_tid[0];
            end else if (take && ins_kind == KW) begin
                sb = 1; sbs = ins_seq; sbt = ins_tid[0];
            end
        end
        if (take) begin
            mv[slot] = 1; mk[slot] = ins_kind; ms[slot] = ins_seq; mt[slot] = ins_tid[0];
            mrr[slot] = ins_regs_ready; mw[slot] = (pidx >= 0); mp[slot] = (pidx >= 0) ? pidx : 0;
            mi[slot] = 0; mpk[slot] = 0;
        end
    endtask

    task automatic clr();
        ins_valid = 0; ins_kind = KL; ins_seq = 0; ins_pc = 0; ins_tid = 0; ins_regs_ready = 0;
        pred_seq = 0; wake_valid = 0; wake_seq = 0; done_valid = 0; done_seq = 0;
        park_valid = 0; park_seq = 0; replay_req = 0; squash_valid = 0; squash_tid = 0;
        squash_seq = 0; ctx_reset = 0; iss_ack = 0;
    endtask

    // Checks combinational and state outputs against the model, then advances one cycle
    task automatic tick();
        int ii;
        #0.5;
        ii = m_iss();
        chk("R8", "ins_full", ins_full, m_full());
        chk("R4", "iss_valid", iss_valid, ii >= 0);
        if (ii >= 0) begin
            chk("R4", "iss_seq", iss_seq, ms[ii]);
            chk("R4", "iss_tid", iss_tid, mt[ii]);
        end
        chk("R3", "ins_blocked", ins_blocked, m_take() && m_find(m_prod_seq()) >= 0);
        if (ins_valid) chk("R3", "pred_pc", pred_pc, ins_pc);
        chk("R9", "pred_clear", pred_clear, ctx_reset);
        mdl_step();
        @(negedge clk);
        clr();
    endtask

    task automatic ins(input logic [1:0] k, input int s, input int t, input bit rr, input int p);
        ins_valid = 1; ins_kind = k; ins_seq = 16'(s); ins_tid = 1'(t); ins_regs_ready = rr;
        pred_seq = 16'(p); ins_pc = 32'(s * 4 + 32'h1000);
    endtask

    task automatic cleanup();
        squash_valid = 1; squash_tid = 0; squash_seq = 0; tick();
        squash_valid = 1; squash_tid = 1; squash_seq = 0; tick();
        chk("R7", "empty after squash", iss_valid, 0);
    endtask

    function automatic logic [15:0] rnd_valid_seq();
        int cnt = 0, pick;
        for (int i = 0; i < N; i++) if (mv[i]) cnt++;
        if (cnt == 0) return 16'd0;
        pick = int'($urandom % cnt);
        for (int i = 0; i < N; i++) if (mv[i]) begin
            if (pick == 0) return ms[i];
            pick--;
        end
        return 16'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nxt;
        void'($urandom(32'd4242));
        clr();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mt[i] = 0; mrr[i] = 0; mw[i] = 0; mi[i] = 0; mpk[i] = 0;
            ms[i] = 0; mk[i] = 0; mp[i] = 0;
        end
        lb = 0; sb = 0; lbt = 0; sbt = 0; lbs = 0; sbs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R4", "reset iss_valid", iss_valid, 0);
        chk("R8", "reset ins_full", ins_full, 0);
        @(negedge clk);

        // R1: full barrier holds loads and stores until it completes
        ins(KF, 10, 0, 1, 0); tick();
        ins(KL, 11, 0, 1, 0); #0.4; chk("R1", "load behind full barrier", ins_blocked, 1); tick();
        ins(KS, 12, 0, 1, 0); #0.4; chk("R1", "store behind full barrier", ins_blocked, 1); tick();
        chk("R1", "held while barrier pending", iss_valid, 0);
        done_valid = 1; done_seq = 10; tick();
        chk("R5", "release after barrier done", iss_seq, 11);
        iss_ack = 1; tick();
        chk("R4", "next offer", iss_seq, 12);
        iss_ack = 1; tick();
        ins(KL, 13, 0, 1, 0); #0.4; chk("R5", "flag cleared on done", ins_blocked, 0); tick();
        cleanup();

        // R2 and R10: write barrier holds stores only, barrier never offered
        ins(KW, 20, 0, 1, 0); tick();
        ins(KL, 21, 0, 1, 0); #0.4; chk("R2", "load passes write barrier", ins_blocked, 0); tick();
        ins(KS, 22, 1, 1, 0); #0.4; chk("R2", "store held by write barrier", ins_blocked, 1); tick();
        chk("R10", "barrier slot skipped", iss_seq, 21);
        cleanup();

        // R3: predictor producers, tracked and untracked
        ins(KS, 30, 0, 0, 0); tick();
        ins(KL, 31, 1, 1, 30); #0.4; chk("R3", "tracked producer", ins_blocked, 1); tick();
        ins(KL, 32, 1, 1, 77); #0.4; chk("R3", "untracked producer", ins_blocked, 0); tick();
        chk("R4", "only free load offered", iss_seq, 32);
        wake_valid = 1; wake_seq = 30; tick();
        chk("R4", "woken store in lowest slot", iss_seq, 30);
        done_valid = 1; done_seq = 30; tick();
        chk("R5", "dependent released", iss_seq, 31);
        cleanup();

        // R11: producer completing in the insert cycle
        ins(KS, 50, 0, 1, 0); tick();
        ins(KL, 51, 0, 1, 50); done_valid = 1; done_seq = 50;
        #0.4; chk("R11", "same-cycle producer done", ins_blocked, 0); tick();
        chk("R11", "offered at once", iss_seq, 51);
        cleanup();

        // R6: park and replay; squash suppresses replay
        ins(KL, 60, 0, 1, 0); tick();
        ins(KL, 61, 0, 1, 0); tick();
        iss_ack = 1; tick();
        iss_ack = 1; tick();
        park_valid = 1; park_seq = 60; tick();
        park_valid = 1; park_seq = 61; tick();
        chk("R6", "parked not offered", iss_valid, 0);
        replay_req = 1; tick();
        chk("R6", "replay releases pool", iss_seq, 60);
        iss_ack = 1; tick();
        iss_ack = 1; tick();
        park_valid = 1; park_seq = 60; tick();
        replay_req = 1; squash_valid = 1; squash_tid = 1; squash_seq = 0; tick();
        chk("R7", "replay ignored under squash", iss_valid, 0);
        replay_req = 1; tick();
        chk("R6", "later replay works", iss_seq, 60);
        cleanup();

        // R7: squash by thread and point, beats insert; squashed barrier drops flag
        ins(KL, 70, 0, 0, 0); tick();
        ins(KL, 71, 1, 0, 0); tick();
        ins(KF, 72, 0, 1, 0); tick();
        squash_valid = 1; squash_tid = 0; squash_seq = 70; ins(KL, 73, 0, 1, 0); tick();
        ins(KL, 74, 1, 1, 0); #0.4; chk("R7", "squashed barrier flag gone", ins_blocked, 0); tick();
        chk("R7", "younger same-thread removed", iss_seq, 74);
        wake_valid = 1; wake_seq = 73; tick();
        iss_ack = 1; tick();
        chk("R7", "insert during squash dropped", iss_valid, 0);
        cleanup();

        // R8: capacity
        for (int i = 0; i < N; i++) begin
            ins(KL, 80 + i, 0, 0, 0); tick();
        end
        chk("R8", "full when all used", ins_full, 1);
        ins(KL, 120, 0, 1, 0); tick();
        chk("R8", "insert while full ignored", iss_valid, 0);
        done_valid = 1; done_seq = 80; tick();
        chk("R8", "not full after free", ins_full, 0);
        cleanup();

        // R9: context reset
        ctx_reset = 1; #0.4; chk("R9", "pred_clear pulse", pred_clear, 1); tick();
        ins(KL, 98, 0, 1, 0); #0.4; chk("R9", "no barrier after reset", ins_blocked, 0); tick();
        cleanup();

        // Random phase against the model
        nxt = 100;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom % 10 < 4) begin
                int kr = int'($urandom % 8);
                int pc = int'($urandom % 3);
                ins(kr < 3 ? KL : kr < 6 ? KS : kr == 6 ? KF : KW, nxt, int'($urandom % 2),
                    bit'($urandom % 2), 0);
                pred_seq = pc == 0 ? 16'd0 : pc == 1 ? rnd_valid_seq() : 16'(nxt + 500);
                nxt++;
            end
            if ($urandom % 3 == 0) begin wake_valid = 1; wake_seq = rnd_valid_seq(); end
            if ($urandom % 2 == 0) iss_ack = 1;
            if ($urandom % 4 == 0) begin done_valid = 1; done_seq = rnd_valid_seq(); end
            if ($urandom % 5 == 0) begin park_valid = 1; park_seq = rnd_valid_seq(); end
            if ($urandom % 12 == 0) replay_req = 1;
            if ($urandom % 25 == 0) begin
                squash_valid = 1; squash_tid = 1'($urandom % 2); squash_seq = rnd_valid_seq();
            end
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule